// File: doc/BRIEF.md
# Command Stream Method Expander

This block sits between the command-list fetch logic and the per-engine routing logic of a graphics front end. It takes a stream of 32-bit words. Some words are command headers and the rest are the argument words that follow them. Each header is decoded, and its arguments are turned into single method writes. Every write carries the subchannel, the method number, the 32-bit value and a countdown of the parameters still to come in that command. Four argument-addressing modes are supported. Inline commands carry a 13-bit immediate in the header itself and have no argument words.

The block also keeps a subchannel-to-engine table. A write to method 0 loads the low bits of its value into the table entry of that write's subchannel. Every forwarded write is tagged with the engine currently bound to its subchannel. A write below 0x100 that is neither the bind method nor one of the macro-setup methods 0x45..0x47 is consumed inside the block. Input and output both use valid/ready handshakes, and the output is a single register stage.

Top module: `cmdx_expander`

## Requirements
- R1: Header layout. Bits [12:0] hold the method, bits [15:13] the subchannel, bits [28:16] the argument count N (the immediate in inline mode), and bits [31:29] the mode. Mode 1 is increasing: argument i is written to method base+i (13-bit).
- R2: Mode 3 (non-increasing) writes every argument to the base method.
- R3: Mode 5 (increase-once) writes argument 0 to the base method and every later argument to base+1.
- R4: Mode 4 (inline) consumes no argument word. It emits one write to the base method with value = zero-extended header bits [28:16] and remaining count 0.
- R5: The write for argument i of an N-argument command carries remaining count N-i-1. After the last argument, the next input word is decoded as a header.
- R6: A write to method 0 stores value[ENG_W-1:0] as the engine of its subchannel. That write is forwarded with out_engine equal to the new engine. Every other forwarded write carries the engine bound to its subchannel at the time it is decoded, including a binding made by the immediately preceding word.
- R7: Writes to methods below 0x100 other than 0, 0x45, 0x46 and 0x47 produce no output write. All other writes are forwarded in input order.
- R8: A header whose mode is not 1, 3, 4 or 5, or an increase-once header with N=0, sets the sticky err_flag and consumes no argument words. The next word is decoded as a header.
- R9: While out_valid is high and out_ready is low, in_ready is low and all output fields hold their values. in_ready is high whenever out_valid is low.
- R10: After reset, out_valid and err_flag are 0, in_ready is 1, and every subchannel is bound to engine 0.
- R11: An increasing or non-increasing header with N=0 produces no write. The next word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts the input word |
| in_word | input | 32 | Header or argument word |
| out_valid | output | 1 | Method write valid |
| out_ready | input | 1 | Routing logic accepts the write |
| out_subch | output | 3 | Subchannel of the write |
| out_method | output | 13 | Method number |
| out_value | output | 32 | Value written |
| out_remain | output | 13 | Parameters remaining after this one |
| out_engine | output | ENG_W | Engine bound to the subchannel |
| err_flag | output | 1 | Sticky malformed-header flag |

## Verification
A binding update and an engine lookup can fall in the same cycle. Two cases provoke this. In the first, an inline bind header is followed directly by a command on the same subchannel. In the second, an increasing command starts at method 0, so the bind and the dropped neighbouring writes share one command. A second overlap is a back-pressure stall that arrives while a command is still expanding. out_ready is held low for many cycles in the middle of multi-argument commands. The reference model judges both: it keeps its own binding table in stream order and compares every accepted write, and on every stalled clock it checks that the output is stable and in_ready is low.

// File: rtl/cmdx_pkg.sv
`timescale 1ns/1ps
package cmdx_pkg;
    localparam int WORD_W   = 32;
    localparam int METH_W   = 13;
    localparam int SUB_W    = 3;
    localparam int CNT_W    = 13;
    localparam int MODE_W   = 3;
    localparam int SUB_LSB  = METH_W;
    localparam int CNT_LSB  = SUB_LSB + SUB_W;
    localparam int MODE_LSB = CNT_LSB + CNT_W;

    localparam logic [MODE_W-1:0] MODE_INCR = 3'd1;
    localparam logic [MODE_W-1:0] MODE_SAME = 3'd3;
    localparam logic [MODE_W-1:0] MODE_IMM  = 3'd4;
    localparam logic [MODE_W-1:0] MODE_ONCE = 3'd5;

    localparam logic [METH_W-1:0] M_BIND      = 13'h000;
    localparam logic [METH_W-1:0] M_MACRO_LO  = 13'h045;
    localparam logic [METH_W-1:0] M_MACRO_HI  = 13'h047;
    localparam logic [METH_W-1:0] M_LOCAL_END = 13'h100;

    typedef struct packed {
        logic              valid;
        logic [SUB_W-1:0]  sub;
        logic [METH_W-1:0] method;
        logic [WORD_W-1:0] value;
        logic [CNT_W-1:0]  remain;
    } mwrite_t;
endpackage

// File: rtl/cmdx_hdr_decode.sv
`timescale 1ns/1ps
module cmdx_hdr_decode
    import cmdx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [METH_W-1:0] method,
    output logic [SUB_W-1:0]  sub,
    output logic [CNT_W-1:0]  cnt,
    output logic [MODE_W-1:0] mode,
    output logic              bad,
    output logic [WORD_W-1:0] imm_val
);
    always_comb begin
        method  = word[METH_W-1:0];
        sub     = word[SUB_LSB +: SUB_W];
        cnt     = word[CNT_LSB +: CNT_W];
        mode    = word[MODE_LSB +: MODE_W];
        imm_val = WORD_W'(cnt);
        bad     = 1'b0;
        if (mode != MODE_INCR && mode != MODE_SAME &&
            mode != MODE_IMM && mode != MODE_ONCE)
            bad = 1'b1;
        if (mode == MODE_ONCE && cnt == '0)
            bad = 1'b1;
    end
endmodule

// File: rtl/cmdx_method_filter.sv
`timescale 1ns/1ps
module cmdx_method_filter
    import cmdx_pkg::*;
(
    input  logic [METH_W-1:0] method,
    output logic              fwd,
    output logic              is_bind
);
    always_comb begin
        is_bind = (method == M_BIND);
        fwd     = 1'b1;
        if (method < M_LOCAL_END && !is_bind &&
            !(method >= M_MACRO_LO && method <= M_MACRO_HI))
            fwd = 1'b0;
    end
endmodule

// File: rtl/cmdx_bind_table.sv
`timescale 1ns/1ps
module cmdx_bind_table
    import cmdx_pkg::*;
#(
    parameter int ENG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SUB_W-1:0] wr_sub,
    input  logic [ENG_W-1:0] wr_eng,
    input  logic [SUB_W-1:0] rd_sub,
    output logic [ENG_W-1:0] rd_eng
);
    localparam int N_SUB = 1 << SUB_W;

    logic [N_SUB-1:0][ENG_W-1:0] ent_d, ent_q;

    for (genvar g = 0; g < N_SUB; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en && wr_sub == SUB_W'(g))
                ent_d[g] = wr_eng;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ent_q <= '0;
        else     ent_q <= ent_d;
    end

    assign rd_eng = ent_q[rd_sub];

    // R6
    tbl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ent_q));
endmodule

// File: rtl/cmdx_expander.sv
`timescale 1ns/1ps
module cmdx_expander
    import cmdx_pkg::*;
#(
    parameter int ENG_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SUB_W-1:0]  out_subch,
    output logic [METH_W-1:0] out_method,
    output logic [WORD_W-1:0] out_value,
    output logic [CNT_W-1:0]  out_remain,
    output logic [ENG_W-1:0]  out_engine,
    output logic              err_flag
);
    typedef struct packed {
        logic              busy;
        logic [MODE_W-1:0] mode;
        logic [METH_W-1:0] base;
        logic [SUB_W-1:0]  sub;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  idx;
        mwrite_t           o;
        logic [ENG_W-1:0]  o_eng;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    logic [METH_W-1:0] h_method;
    logic [SUB_W-1:0]  h_sub;
    logic [CNT_W-1:0]  h_cnt;
    logic [MODE_W-1:0] h_mode;
    logic              h_bad;
    logic [WORD_W-1:0] h_imm;
    mwrite_t           gen;
    logic              fwd, is_bind, accept;
    logic [ENG_W-1:0]  rd_eng;

    cmdx_hdr_decode u_dec (
        .word(in_word), .method(h_method), .sub(h_sub), .cnt(h_cnt),
        .mode(h_mode), .bad(h_bad), .imm_val(h_imm)
    );

    cmdx_method_filter u_filt (
        .method(gen.method), .fwd(fwd), .is_bind(is_bind)
    );

    cmdx_bind_table #(.ENG_W(ENG_W)) u_tbl (
        .clk(clk), .rst(rst),
        .wr_en(gen.valid && is_bind), .wr_sub(gen.sub),
        .wr_eng(gen.value[ENG_W-1:0]),
        .rd_sub(gen.sub), .rd_eng(rd_eng)
    );

    assign in_ready = !st_q.o.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        gen  = '0;

        if (accept && !st_q.busy) begin
            if (h_bad) begin
                st_d.err = 1'b1;
            end else if (h_mode == MODE_IMM) begin
                gen.valid  = 1'b1;
                gen.sub    = h_sub;
                gen.method = h_method;
                gen.value  = h_imm;
                gen.remain = '0;
            end else if (h_cnt != '0) begin
                st_d.busy = 1'b1;
                st_d.mode = h_mode;
                st_d.base = h_method;
                st_d.sub  = h_sub;
                st_d.cnt  = h_cnt;
                st_d.idx  = '0;
            end
        end else if (accept) begin
            gen.valid  = 1'b1;
            gen.sub    = st_q.sub;
            gen.value  = in_word;
            gen.remain = st_q.cnt - st_q.idx - 1'b1;
            case (st_q.mode)
                MODE_INCR: gen.method = st_q.base + METH_W'(st_q.idx);
                MODE_ONCE: gen.method = (st_q.idx == '0) ? st_q.base
                                                         : st_q.base + 1'b1;
                default:   gen.method = st_q.base;
            endcase
            st_d.idx = st_q.idx + 1'b1;
            if (gen.remain == '0)
                st_d.busy = 1'b0;
        end

        if (!st_q.o.valid || out_ready) begin
            st_d.o.valid = gen.valid && fwd;
            if (gen.valid && fwd) begin
                st_d.o     = gen;
                st_d.o_eng = is_bind ? gen.value[ENG_W-1:0] : rd_eng;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid  = st_q.o.valid;
    assign out_subch  = st_q.o.sub;
    assign out_method = st_q.o.method;
    assign out_value  = st_q.o.value;
    assign out_remain = st_q.o.remain;
    assign out_engine = st_q.o_eng;
    assign err_flag   = st_q.err;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_method)
        && $stable(out_value) && $stable(out_remain) && $stable(out_subch)
        && $stable(out_engine));
    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);
    // R5
    last_arg_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        accept && st_q.busy && st_q.idx + 1'b1 == st_q.cnt |=> !st_q.busy);
endmodule

// File: tb/test_cmdx_expander.sv
`timescale 1ns/1ps
module test_cmdx_expander;
    localparam int EW = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_subch;
    logic [12:0] out_method;
    logic [31:0] out_value;
    logic [12:0] out_remain;
    logic [EW-1:0] out_engine;
    logic        err_flag;

    cmdx_expander #(.ENG_W(EW)) i_cmdx_expander (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_subch(out_subch), .out_method(out_method), .out_value(out_value),
        .out_remain(out_remain), .out_engine(out_engine), .err_flag(err_flag)
    );

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int rdy_mode = 0;
    bit done = 0;

    typedef struct packed {
        logic [2:0]    sub;
        logic [12:0]   method;
        logic [31:0]   value;
        logic [12:0]   remain;
        logic [EW-1:0] eng;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [EW-1:0] eng_m[8];

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic expect_wr(input logic [2:0] sub, input logic [12:0] m,
                             input logic [31:0] v, input logic [12:0] rem,
                             input string tag);
        exp_t e;
        bit fwd;
        logic [EW-1:0] eng;
        fwd = !(m < 13'h100 && m != 0 && !(m >= 13'h45 && m <= 13'h47));
        if (m == 0) begin
            eng_m[sub] = v[EW-1:0];
            eng = v[EW-1:0];
        end else begin
            eng = eng_m[sub];
        end
        e = '{sub: sub, method: m, value: v, remain: rem, eng: eng};
        if (fwd) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] hdr(input logic [2:0] mode, input logic [12:0] n,
                                        input logic [2:0] sub, input logic [12:0] m);
        return {mode, n, sub, m};
    endfunction

    // mode: 1 increasing, 3 same, 5 increase-once
    task automatic cmd(input logic [2:0] mode, input logic [12:0] m,
                       input logic [2:0] sub, input int n,
                       input logic [31:0] seed, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [12:0] mi;
            if (mode == 3'd1)      mi = m + 13'(i);
            else if (mode == 3'd5) mi = (i == 0) ? m : m + 13'd1;
            else                   mi = m;
            expect_wr(sub, mi, seed + 32'(i * 32'h01010101), 13'(n - i - 1), tag);
        end
        send_word(hdr(mode, 13'(n), sub, m));
        for (int i = 0; i < n; i++)
            send_word(seed + 32'(i * 32'h01010101));
    endtask

    task automatic inline_cmd(input logic [12:0] m, input logic [2:0] sub,
                              input logic [12:0] imm, input string tag);
        expect_wr(sub, m, 32'(imm), 13'd0, tag);
        send_word(hdr(3'd4, imm, sub, m));
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_q.size() != 0 || out_valid) && n < 500) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    // Monitor: compares every accepted write and every stalled clock
    bit   prev_stall = 0;
    exp_t prev_out;
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            exp_t got;
            got = '{sub: out_subch, method: out_method, value: out_value,
                    remain: out_remain, eng: out_engine};
            if (prev_stall)
                check(out_valid && got == prev_out, "R9",
                      $sformatf("stalled write changed got %h exp %h", got, prev_out));
            if (out_valid && !out_ready)
                check(!in_ready, "R9", $sformatf("in_ready=%0d exp 0 while stalled", in_ready));
            if (!out_valid)
                check(in_ready, "R9", $sformatf("in_ready=%0d exp 1 while idle", in_ready));
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7", $sformatf("unexpected write got %h exp none", got));
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(got == e, t, $sformatf("write got %h exp %h", got, e));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_out   = got;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 8; s++) eng_m[s] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #1;
        // R10 reset state
        check(out_valid == 0, "R10", $sformatf("out_valid got %0d exp 0", out_valid));
        check(err_flag == 0, "R10", $sformatf("err_flag got %0d exp 0", err_flag));
        check(in_ready == 1, "R10", $sformatf("in_ready got %0d exp 1", in_ready));

        // R10 unbound subchannel tagged engine 0; R1 increasing; R5 countdown
        cmd(3'd1, 13'h200, 3'd1, 4, 32'hA000_0000, "R1");
        // R2 non-increasing
        cmd(3'd3, 13'h300, 3'd2, 3, 32'hB000_0010, "R2");
        // R3 increase-once, long and single
        cmd(3'd5, 13'h400, 3'd3, 4, 32'hC000_0020, "R3");
        cmd(3'd5, 13'h410, 3'd3, 1, 32'hC100_0030, "R3");
        // R4 inline immediate
        inline_cmd(13'h500, 3'd4, 13'h1ABC, "R4");
        drain();

        // R6 inline bind immediately followed by a write on the same subchannel
        inline_cmd(13'h000, 3'd1, 13'h0007, "R6");
        cmd(3'd1, 13'h210, 3'd1, 2, 32'hD000_0000, "R6");
        // R6 bind at start of an increasing command; R7 methods 1 and 2 dropped
        cmd(3'd1, 13'h000, 3'd5, 3, 32'h0000_0013, "R6");
        cmd(3'd3, 13'h600, 3'd5, 2, 32'hE000_0000, "R6");
        drain();

        // R7 local method dropped, macro setup methods forwarded
        cmd(3'd3, 13'h010, 3'd0, 2, 32'h1111_0000, "R7");
        cmd(3'd1, 13'h045, 3'd0, 3, 32'h2222_0000, "R7");
        // R11 zero-count headers
        send_word(hdr(3'd1, 13'd0, 3'd2, 13'h700));
        send_word(hdr(3'd3, 13'd0, 3'd2, 13'h700));
        cmd(3'd1, 13'h720, 3'd2, 2, 32'h3333_0000, "R11");
        drain();
        check(err_flag == 0, "R11", $sformatf("err_flag got %0d exp 0", err_flag));

        // R8 increase-once with zero args, then a word treated as header
        send_word(hdr(3'd5, 13'd0, 3'd6, 13'h800));
        drain();
        check(err_flag == 1, "R8", $sformatf("err_flag got %0d exp 1", err_flag));
        cmd(3'd3, 13'h810, 3'd6, 2, 32'h4444_0000, "R8");
        // R8 unknown mode
        send_word(hdr(3'd0, 13'd3, 3'd6, 13'h820));
        cmd(3'd1, 13'h830, 3'd6, 2, 32'h5555_0000, "R8");
        drain();
        check(err_flag == 1, "R8", $sformatf("err_flag got %0d exp 1 (sticky)", err_flag));

        // R9 long stall during expansion, then random back-pressure
        fork
            cmd(3'd1, 13'h900, 3'd7, 6, 32'h6666_0000, "R9");
            begin
                repeat (3) @(posedge clk);
                rdy_mode = 2;
                repeat (12) @(posedge clk);
                rdy_mode = 1;
            end
        join
        cmd(3'd5, 13'hA00, 3'd7, 5, 32'h7777_0000, "R9");
        inline_cmd(13'h000, 3'd7, 13'h001E, "R6");
        cmd(3'd3, 13'hA10, 3'd7, 3, 32'h8888_0000, "R9");
        drain();
        rdy_mode = 0;
        drain();
        check(exp_q.size() == 0, "R7",
              $sformatf("pending writes got %0d exp 0", exp_q.size()));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule